// File: doc/BRIEF.md
# Parallel-Memory Configuration Serializer

This block is the master side of a configuration load. It reads a byte-wide parallel memory and sends the contents on as one serial bitstream. Once a start is accepted it drives an address bus that begins at zero, pulses a slow read strobe once per byte, and captures the byte on the strobe's rising edge. It then shifts the byte out, least significant bit first, on a serial data line. A bit clock that runs eight times faster than the read strobe goes with the data line, so that devices further down a daisy chain can sample the data.

All timing comes from one internal clock. A 16-cycle phase counter sets the pace: one byte slot lasts 16 cycles and one bit lasts 2 cycles. The read strobe is high for the second half of each slot. The bit clock is high on odd phases, and the data line moves only on the edges where the bit clock falls. The first byte is fetched during a slot in which nothing is shifted. Every later byte is fetched while the one before it is still shifting, so the serial stream has no gaps. An option reverses the bit order of the input bus for memory images that were stored bit-mirrored.

Top module: `cfg_par_serializer`

## Requirements
- R1: Reset (asynchronous, active low), whether it comes while idle or part way through a load, returns the address to 0 and drives the bit clock, the read strobe, the serial data, busy, done and error low.
- R2: A start pulse with a nonzero byte count, seen while idle, raises busy in the next cycle with the address at 0.
- R3: The address rises by exactly one on each clock edge that captures a byte, and holds otherwise.
- R4: In each 16-cycle byte slot that fetches a byte, the read strobe is low for phases 0 to 7 and high for phases 8 to 15, so it rises on the capture edge. In each shifting slot the bit clock is high on odd phases and low on even phases, which gives eight bit-clock periods per read-strobe period.
- R5: With the mirror option off, byte n (read from address n) is sent in slot n+1, with data bit k held on the serial line during phases 2k and 2k+1, so bit 0 goes first.
- R6: The serial data changes only on edges that leave the bit clock low. It is stable while the bit clock is high.
- R7: Consecutive bytes follow each other with no gap: bit 0 of byte n+1 comes right after bit 7 of byte n.
- R8: With the mirror option on, memory data bit 7-k is used as bit k of the byte.
- R9: For a count of N bytes, done is high for exactly one cycle, 16·(N+1) cycles after the accepted start, and busy falls in that same cycle.
- R10: A start pulse while busy is ignored: the count, the address sequence and the completion time stay those of the running load.
- R11: A start pulse with a byte count of 0 is ignored: busy, the read strobe and done stay low.
- R12: If a byte is captured from the maximum address (all ones, 0x3FFFF at the default width) while more bytes are still owed, the load stops on that edge: busy drops, the clocks and data go low, done is not raised, and error stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| byte_count_i | input | ADDR_W+1 | Number of bytes to load, sampled at start |
| mirror_i | input | 1 | 1 = reverse the bit order of the data bus |
| mem_addr_o | output | ADDR_W (18) | Memory address |
| mem_rclk_o | output | 1 | Read strobe; data is captured on its rising edge |
| mem_data_i | input | 8 | Memory data bus |
| cclk_o | output | 1 | Serial bit clock |
| dout_o | output | 1 | Serial data, changes on falling bit clock |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse when the last bit has been sent |
| error_o | output | 1 | Address space exhausted before the count |

## Verification
The in-line assertions watch every cycle for the following: the phase counter steps by one while running, the address increments on each capture, the first bit of a loaded byte is bit 0, the data line never moves while the bit clock is high, done is a single cycle with busy low, an idle block keeps its outputs quiet, and error never coincides with busy. Only the directed scenarios can show the parts that depend on the data and the schedule. These are the exact byte values and bit order with and without mirroring, the gap-free joins between bytes, the exact done cycle for a given count, the overflow point at the top address, and the fact that a start during a load or with a zero count leaves no trace.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  // two internal cycles per bit: one low and one high bit-clock phase
  localparam int unsigned PH_W   = BIT_W + 1;
  localparam logic [PH_W-1:0] PH_CAP  = PH_W'(BYTE_W - 1);
  localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};
endpackage

// File: rtl/cfgser_timing.sv
module cfgser_timing
  import cfgser_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  output logic [PH_W-1:0] ph_o,
  output logic            cap_slot_o,
  output logic            end_slot_o
);
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = run_i ? ph_q + PH_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph_o       = ph_q;
  assign cap_slot_o = run_i && (ph_q == PH_CAP);
  assign end_slot_o = run_i && (ph_q == PH_LAST);

  // R4: the phase advances by one per cycle while a load runs
  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i)) |-> (ph_q == PH_W'($past(ph_q) + PH_W'(1))));
endmodule

// File: rtl/cfgser_fetch.sv
module cfgser_fetch
  import cfgser_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic              mirror_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_max_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [BYTE_W-1:0] rev;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign rev[i] = data_i[BYTE_W-1-i];
  end

  always_comb begin
    addr_d = addr_q;
    hold_d = hold_q;
    if (clear_i) begin
      addr_d = '0;
    end else if (cap_i) begin
      addr_d = addr_q + ADDR_W'(1);
      hold_d = mirror_i ? rev : data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      hold_q <= '0;
    end else begin
      addr_q <= addr_d;
      hold_q <= hold_d;
    end
  end

  assign addr_o   = addr_q;
  assign at_max_o = (addr_q == {ADDR_W{1'b1}});
  assign byte_o   = hold_q;

  // R3: one step per captured byte
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !clear_i) |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1))));
  // R2: an accepted start begins at address zero
  assert_addr_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (addr_q == '0));
endmodule

// File: rtl/cfgser_shift.sv
module cfgser_shift
  import cfgser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  output logic              act_o,
  output logic              dout_o
);
  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic              act_q, act_d;

  always_comb begin
    sreg_d = sreg_q;
    act_d  = act_q;
    if (stop_i) begin
      act_d = 1'b0;
    end else if (load_i) begin
      sreg_d = byte_i;
      act_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      act_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      act_q  <= act_d;
    end
  end

  assign act_o  = act_q;
  assign dout_o = act_q & sreg_q[bit_idx_i];

  // R5: a freshly loaded byte shows its least significant bit first
  assert_lsb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !stop_i) |=> (dout_o == $past(byte_i[0])));
endmodule

// File: rtl/cfg_par_serializer.sv
module cfg_par_serializer
  import cfgser_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W:0]   byte_count_i,
  input  logic              mirror_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rclk_o,
  input  logic [7:0]        mem_data_i,
  output logic              cclk_o,
  output logic              dout_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int unsigned CNT_W = ADDR_W + 1;

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             pend_q, pend_d;
  logic             rclk_q, rclk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] got_q, got_d;

  logic [PH_W-1:0]   ph;
  logic              cap_slot, end_slot;
  logic              accept, cap, ovf, load, finish;
  logic              at_max, shift_act;
  logic [BYTE_W-1:0] held_byte;

  cfgser_timing u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (busy_q),
    .ph_o       (ph),
    .cap_slot_o (cap_slot),
    .end_slot_o (end_slot)
  );

  cfgser_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .cap_i    (cap),
    .mirror_i (mirror_i),
    .data_i   (mem_data_i),
    .addr_o   (mem_addr_o),
    .at_max_o (at_max),
    .byte_o   (held_byte)
  );

  cfgser_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .stop_i    (finish | ovf),
    .byte_i    (held_byte),
    .bit_idx_i (ph[PH_W-1:1]),
    .act_o     (shift_act),
    .dout_o    (dout_o)
  );

  always_comb begin
    accept = start_i && !busy_q && (byte_count_i != '0);
    cap    = cap_slot && (got_q < cnt_q);
    ovf    = cap && at_max && ((got_q + CNT_W'(1)) < cnt_q);
    load   = end_slot && pend_q;
    finish = end_slot && !pend_q && shift_act;
  end

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    pend_d = pend_q;
    rclk_d = rclk_q;
    cnt_d  = cnt_q;
    got_d  = got_q;
    done_d = finish;
    if (accept) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
      pend_d = 1'b0;
      cnt_d  = byte_count_i;
      got_d  = '0;
    end else if (ovf) begin
      busy_d = 1'b0;
      err_d  = 1'b1;
      pend_d = 1'b0;
      rclk_d = 1'b0;
    end else begin
      if (cap) begin
        pend_d = 1'b1;
        rclk_d = 1'b1;
        got_d  = got_q + CNT_W'(1);
      end
      if (end_slot) begin
        rclk_d = 1'b0;
      end
      if (load) begin
        pend_d = 1'b0;
      end
      if (finish) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      rclk_q <= 1'b0;
      cnt_q  <= '0;
      got_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      pend_q <= pend_d;
      rclk_q <= rclk_d;
      cnt_q  <= cnt_d;
      got_q  <= got_d;
    end
  end

  assign cclk_o     = shift_act & ph[0];
  assign mem_rclk_o = rclk_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign error_o    = err_q;

  // R1: nothing toggles while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!cclk_o && !mem_rclk_o && !dout_o));
  // R6: data moves only with the bit clock low
  assert_dout_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_o) |-> !cclk_o);
  // R9: done is a single cycle, with busy already low
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q ##1 !done_q));
  // R10: a start during a load leaves the programmed count alone
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(cnt_q));
  // R12: an overflowed load is no longer running
  assert_no_overflow_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy_q && !done_q));
endmodule

// File: tb/cfg_par_serializer_tb_top.sv
module cfg_par_serializer_tb_top;
  localparam int AW = 6;
  localparam int CW = AW + 1;
  localparam int SLOT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mirror = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic [AW-1:0] addr;
  logic [7:0]    mem;
  logic          rclk, cclk, dout, busy, done, err;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [AW-1:0] a);
    logic [31:0] v;
    v = 32'(a) * 32'd29 + 32'd75;
    return v[7:0];
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  assign mem = mem_fn(addr);

  cfg_par_serializer #(.ADDR_W(AW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .byte_count_i (cnt_in),
    .mirror_i     (mirror),
    .mem_addr_o   (addr),
    .mem_rclk_o   (rclk),
    .mem_data_i   (mem),
    .cclk_o       (cclk),
    .dout_o       (dout),
    .busy_o       (busy),
    .done_o       (done),
    .error_o      (err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_quiet(input string req);
    check(req, "busy", int'(busy), 0);
    check(req, "done", int'(done), 0);
    check(req, "rclk", int'(rclk), 0);
    check(req, "cclk", int'(cclk), 0);
    check(req, "dout", int'(dout), 0);
  endtask

  // reset at power-up: everything idle, address 0 (R1)
  task automatic t_reset_idle();
    repeat (3) @(negedge clk);
    check_quiet("R1");
    check("R1", "error", int'(err), 0);
    check("R1", "addr", int'(addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1");
  endtask

  // full load with cycle-by-cycle expectations; poke_k >= 0 fires a start mid-load
  task automatic t_load(input int n, input bit m, input int poke_k);
    int  e, p, ea;
    int  eb;
    int  prev_dout;
    string dreq;
    @(negedge clk);
    cnt_in = CW'(n);
    mirror = m;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev_dout = 0;
    for (int k = 0; k <= SLOT * (n + 1); k++) begin
      if (k == poke_k) begin
        start  = 1'b1;
        cnt_in = CW'(1);
      end else if (k == poke_k + 1) begin
        start  = 1'b0;
        cnt_in = CW'(n);
      end
      e = k / SLOT;
      p = k % SLOT;
      if (k == SLOT * (n + 1)) begin
        check("R9", "done", int'(done), 1);
        check("R9", "busy", int'(busy), 0);
        check("R9", "cclk", int'(cclk), 0);
        check("R9", "dout", int'(dout), 0);
        if (poke_k >= 0) check("R10", "done on original schedule", int'(done), 1);
      end else begin
        check(k == 0 ? "R2" : "R9", "busy", int'(busy), 1);
        check("R9", "done", int'(done), 0);
        check("R12", "error", int'(err), 0);
        if (e < n) ea = (p >= 8) ? e + 1 : e;
        else       ea = n;
        check(k == 0 ? "R2" : "R3", "addr", int'(addr), ea & ((1 << AW) - 1));
        check("R4", "rclk", int'(rclk), (e < n && p >= 8) ? 1 : 0);
        check("R4", "cclk", int'(cclk), (e >= 1 && (p % 2) == 1) ? 1 : 0);
        if (e >= 1) begin
          eb = int'(mem_fn(AW'(e - 1)));
          if (m) eb = int'(rev8(8'(eb)));
          if (p == 0 && e >= 2) dreq = "R7";
          else if (m)           dreq = "R8";
          else                  dreq = "R5";
          check(dreq, "dout", int'(dout), (eb >> (p / 2)) & 1);
          if ((p % 2) == 1) check("R6", "dout stable while cclk high", int'(dout), prev_dout);
        end else begin
          check("R5", "dout before first byte", int'(dout), 0);
        end
        if (poke_k >= 0 && k == poke_k + 2) check("R10", "busy kept", int'(busy), 1);
      end
      prev_dout = int'(dout);
      @(negedge clk);
    end
    check("R9", "done single cycle", int'(done), 0);
  endtask

  // zero byte count: start has no effect (R11)
  task automatic t_zero_count();
    @(negedge clk);
    cnt_in = '0;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20; k++) begin
      check_quiet("R11");
      @(negedge clk);
    end
  endtask

  // count larger than the address space: stop at the top address (R12)
  task automatic t_overflow();
    int stop_k;
    stop_k = SLOT * ((1 << AW) - 1) + 8;
    @(negedge clk);
    cnt_in = CW'(70);
    mirror = 1'b0;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < stop_k; k++) begin
      if (k == stop_k - 1) begin
        check("R12", "busy before top capture", int'(busy), 1);
        check("R12", "error before top capture", int'(err), 0);
      end
      @(negedge clk);
    end
    check("R12", "error", int'(err), 1);
    check_quiet("R12");
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R12", "no done after overflow", int'(done), 0);
      check("R12", "error held", int'(err), 1);
    end
  endtask

  // reset in the middle of a load (R1)
  task automatic t_reset_mid();
    @(negedge clk);
    cnt_in = CW'(5);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (41) @(negedge clk);
    check("R1", "busy before reset", int'(busy), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check_quiet("R1");
    check("R1", "addr", int'(addr), 0);
    check("R1", "error", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1");
  endtask

  initial begin
    t_reset_idle();
    t_load(3, 1'b0, -1);
    t_load(5, 1'b1, -1);
    t_load(4, 1'b0, 20);
    t_zero_count();
    t_load(1 << AW, 1'b0, -1);
    t_overflow();
    t_load(2, 1'b0, -1);
    t_reset_mid();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule